// File: doc/BRIEF.md
# Two-Bank Special-Function-Register Decoder

This block sits between the CPU's direct-address data path and the special-function registers (SFRs). Every direct address with its top bit set falls in the SFR window (0x80 to 0xFF), and two register banks share that window: a standard bank and a mapped bank. Which bank an access reaches depends on a bank bit held in a control register at a fixed window address. The instruction's address does not carry the bank. This doubles the number of reachable SFRs without widening the address.

Each access drives one bank-qualified select line for the addressed register and steers that register's read data back to the CPU. The control register holding the bank bit sits at the same address in both banks, so software can always switch back. The bank bit only changes when software writes the control register. A write to it takes effect on the following access.

Top module: `sfr_bank_decoder`

## Requirements
- R1: After reset the control register at 0x8F reads 0x00, the bank bit (bit 0 of that register) is 0 and the standard bank is active.
- R2: An access to an address below 0x80 asserts no select line in either bank and returns read data 0x00.
- R3: With the bank bit at 0, an access to an implemented window address A other than 0x8F asserts only standard select line A-0x80, and a read returns that standard register's data.
- R4: With the bank bit at 1, the same access asserts only mapped select line A-0x80, and a read returns that mapped register's data.
- R5: Address 0x8F decodes to the control register in both banks. A read returns the last byte written to it, and no peripheral select line is asserted for it.
- R6: An access to an address that the active bank does not implement asserts no select line, and a read returns 0x00.
- R7: A write to 0x8F changes the active bank (bit 0 of the written byte: 1 mapped, 0 standard) starting with the next access. The access that performs the write is still decoded in the old bank.
- R8: The bank bit holds its value across reads of 0x8F and across writes to any other address.
- R9: With neither the read nor the write strobe active, no select line is asserted and read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | Direct address of the access |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data back to the CPU |
| std_rdata | input | 1024 | Read data of the 128 standard-bank slots, slot i at bits [8i+7:8i] |
| map_rdata | input | 1024 | Read data of the 128 mapped-bank slots, same packing |
| std_sel | output | 128 | Standard-bank select, bit i for address 0x80+i |
| map_sel | output | 128 | Mapped-bank select, bit i for address 0x80+i |
| map_active | output | 1 | 1 while the mapped bank is the active bank |

## Verification
The bench sweeps all 256 direct addresses, with reads and with writes, once in each bank. It compares the full select vectors and the read data against masks and slot values that the bench computes itself. The implementation masks deliberately mark slot 0x8F as present, so a decoder that let a peripheral answer at the control address would raise a select line or return the wrong byte there. The bench checks the active bank during the very cycle that writes 0x8F, which catches a decoder that switches one access early. It also writes bytes with bit 0 set to every other address and then reads 0x8F back, which exposes a bank bit that loads on the wrong address. Idle cycles and addresses below the window confirm that the decoder drives nothing without a strobe or outside the window.

// File: rtl/sfr_bank_pkg.sv
package sfr_bank_pkg;
  typedef enum logic {
    BANK_STD = 1'b0,
    BANK_MAP = 1'b1
  } bank_e;

  typedef struct packed {
    logic acc;       // a read or write strobe is active
    logic win_hit;   // address lies inside the SFR window
    logic ctrl_hit;  // address is the bank control register
  } dec_flags_t;
endpackage

// File: rtl/sfr_addr_decode.sv
module sfr_addr_decode
  import sfr_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F,
  localparam int OFF_W = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output dec_flags_t        flags,
  output logic [OFF_W-1:0]  off
);
  // Window membership: top address bit set.
  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1];
  endfunction

  always_comb begin
    flags.acc      = rd | wr;
    flags.win_hit  = in_window(addr);
    flags.ctrl_hit = (addr == CTRL_ADDR);
    off            = addr[OFF_W-1:0];
  end
endmodule

// File: rtl/sfr_bank_ctrl.sv
module sfr_bank_ctrl
  import sfr_bank_pkg::*;
#(
  parameter int DW = 8,
  parameter int BANK_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output bank_e         bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata;
  end

  assign bank = bank_e'(ctrl_q[BANK_BIT]);

  // R7: a control write lands on the next cycle
  a_r7_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == $past(wdata));
  // R8: nothing but a control write moves the register
  a_r8_ctrl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/sfr_bank_port.sv
module sfr_bank_port #(
  parameter int DW = 8,
  parameter int OFF_W = 7,
  localparam int SLOTS = 2 ** OFF_W,
  parameter logic [SLOTS-1:0] IMPL = '1
) (
  input  logic               en,
  input  logic               rd,
  input  logic [OFF_W-1:0]   off,
  input  logic [SLOTS*DW-1:0] slot_rdata,
  output logic [SLOTS-1:0]   sel,
  output logic [DW-1:0]      rdata
);
  logic [DW-1:0] slot_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (IMPL[i]) begin : g_impl
      assign sel[i] = en && (off == OFF_W'(i));
    end else begin : g_hole
      assign sel[i] = 1'b0;
    end
    assign slot_q[i] = slot_rdata[i*DW +: DW];
  end

  assign rdata = (rd && (|sel)) ? slot_q[off] : '0;

  // R6: no select is ever raised while the port is disabled
  a_r6_port_quiet: assert final (en || sel == '0);
endmodule

// File: rtl/sfr_bank_decoder.sv
module sfr_bank_decoder
  import sfr_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW = 8,
  parameter int BANK_BIT = 0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F,
  localparam int OFF_W = ADDR_W - 1,
  localparam int SLOTS = 2 ** OFF_W,
  parameter logic [SLOTS-1:0] STD_IMPL = 128'h0000_FFFF_0F0F_00FF_F0F0_FFFF_0000_80FF,
  parameter logic [SLOTS-1:0] MAP_IMPL = 128'hFFFF_0000_3333_AAAA_0000_FF00_5555_80F0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  input  logic [DW-1:0]       cpu_wdata,
  output logic [DW-1:0]       cpu_rdata,
  input  logic [SLOTS*DW-1:0] std_rdata,
  input  logic [SLOTS*DW-1:0] map_rdata,
  output logic [SLOTS-1:0]    std_sel,
  output logic [SLOTS-1:0]    map_sel,
  output logic                map_active
);
  dec_flags_t       flags;
  logic [OFF_W-1:0] off;
  logic [DW-1:0]    ctrl_q;
  bank_e            bank;
  logic             wr_ctrl;
  logic             periph_acc;
  logic [DW-1:0]    std_rd_q, map_rd_q;

  sfr_addr_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_dec (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .flags(flags), .off(off)
  );

  assign wr_ctrl    = cpu_wr && flags.ctrl_hit;
  assign periph_acc = flags.acc && flags.win_hit && !flags.ctrl_hit;

  sfr_bank_ctrl #(.DW(DW), .BANK_BIT(BANK_BIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(cpu_wdata),
    .ctrl_q(ctrl_q), .bank(bank)
  );

  sfr_bank_port #(.DW(DW), .OFF_W(OFF_W), .IMPL(STD_IMPL)) u_std (
    .en(periph_acc && bank == BANK_STD), .rd(cpu_rd), .off(off),
    .slot_rdata(std_rdata), .sel(std_sel), .rdata(std_rd_q)
  );

  sfr_bank_port #(.DW(DW), .OFF_W(OFF_W), .IMPL(MAP_IMPL)) u_map (
    .en(periph_acc && bank == BANK_MAP), .rd(cpu_rd), .off(off),
    .slot_rdata(map_rdata), .sel(map_sel), .rdata(map_rd_q)
  );

  always_comb begin
    if (!cpu_rd)                cpu_rdata = '0;
    else if (flags.ctrl_hit)    cpu_rdata = ctrl_q;
    else if (bank == BANK_MAP)  cpu_rdata = map_rd_q;
    else                        cpu_rdata = std_rd_q;
  end

  assign map_active = (bank == BANK_MAP);

  // R3: at most one select line across both banks
  a_r3_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({map_sel, std_sel}));
  // R4: a mapped select only while the mapped bank is active
  a_r4_map_needs_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (|map_sel) |-> map_active);
  // R3: a standard select only while the standard bank is active
  a_r3_std_needs_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (|std_sel) |-> !map_active);
  // R2: below the window nothing is selected or returned
  a_r2_below_window: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[ADDR_W-1] |-> (std_sel == '0 && map_sel == '0 && cpu_rdata == '0));
  // R5: the control address never reaches a peripheral
  a_r5_ctrl_private: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr == CTRL_ADDR |-> (std_sel == '0 && map_sel == '0));
  // R9: idle bus drives nothing
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd && !cpu_wr) |-> (std_sel == '0 && map_sel == '0 && cpu_rdata == '0));
  // R7: the bank only moves after a control write
  a_r7_bank_change: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(map_active));
endmodule

// File: tb/tb_sfr_bank_decoder.sv
module tb_sfr_bank_decoder;
  localparam logic [127:0] STD_M = 128'h0000_FFFF_0F0F_00FF_F0F0_FFFF_0000_80FF;
  localparam logic [127:0] MAP_M = 128'hFFFF_0000_3333_AAAA_0000_FF00_5555_80F0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [7:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic cpu_rd, cpu_wr, map_active;
  logic [1023:0] std_rdata, map_rdata;
  logic [127:0] std_sel, map_sel;

  sfr_bank_decoder #(.STD_IMPL(STD_M), .MAP_IMPL(MAP_M)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .std_rdata(std_rdata), .map_rdata(map_rdata), .std_sel(std_sel),
    .map_sel(map_sel), .map_active(map_active)
  );

  int errs = 0;
  int checks = 0;
  logic [7:0] ctrl_m = 8'h00;

  function automatic logic [7:0] slot_val(input bit mapped, input int idx);
    if (mapped) return 8'((idx * 7 + 13) & 255);
    return 8'(idx) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] a, input logic rd, input logic wr, input logic [7:0] wd);
    logic [127:0] es, em;
    logic [7:0] er;
    bit mapped;
    bit impl;
    string req;
    int off;
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    #2;
    mapped = ctrl_m[0];
    off = int'(a[6:0]);
    es = '0; em = '0; er = 8'h00;
    impl = mapped ? MAP_M[off] : STD_M[off];
    if (!rd && !wr)         req = "R9";
    else if (!a[7])         req = "R2";
    else if (a == 8'h8F)    req = "R5";
    else if (!impl)         req = "R6";
    else                    req = mapped ? "R4" : "R3";
    if ((rd || wr) && a[7]) begin
      if (a == 8'h8F) begin
        if (rd) er = ctrl_m;
      end else if (impl) begin
        if (mapped) em[off] = 1'b1; else es[off] = 1'b1;
        if (rd) er = slot_val(mapped, off);
      end
    end
    chk(req, 128'(cpu_rdata), 128'(er));
    chk(req, std_sel, es);
    chk(req, map_sel, em);
    chk((wr && a == 8'h8F) ? "R7" : "R8", 128'(map_active), 128'(mapped));
    if (wr && a == 8'h8F) ctrl_m = wd;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      std_rdata[i*8 +: 8] = slot_val(1'b0, i);
      map_rdata[i*8 +: 8] = slot_val(1'b1, i);
    end
    rst_n = 1'b0; cpu_addr = 8'h8F; cpu_rd = 1'b1; cpu_wr = 1'b0; cpu_wdata = 8'h00;
    repeat (3) @(negedge clk);
    #2;
    chk("R1", 128'(cpu_rdata), 128'h00);
    chk("R1", 128'(map_active), 128'h0);
    @(negedge clk);
    rst_n = 1'b1;
    access(8'h8F, 1'b1, 1'b0, 8'h00);   // R1 after release
    access(8'h85, 1'b0, 1'b0, 8'h00);   // R9 idle
    access(8'h10, 1'b0, 1'b0, 8'h00);   // R9 idle
    for (int b = 0; b < 2; b++) begin
      // R3 / R4 / R6 / R2 / R5 read sweep
      for (int a = 0; a < 256; a++) access(8'(a), 1'b1, 1'b0, 8'h00);
      // write sweep, bit 0 set, skipping the control address (R8)
      for (int a = 0; a < 256; a++)
        if (a != 8'h8F) access(8'(a), 1'b0, 1'b1, 8'hFF);
      access(8'h8F, 1'b1, 1'b0, 8'h00);  // R8 still unchanged
      access(8'h8F, 1'b1, 1'b0, 8'h00);  // R8 read does not move it
      // R7: switch bank; old bank during the write, new bank after
      access(8'h8F, 1'b0, 1'b1, b == 0 ? 8'hC3 : 8'h02);
      access(8'h8F, 1'b1, 1'b0, 8'h00);  // R5 read back
    end
    // back in standard bank: R7 again, switch through the mapped side
    access(8'h8F, 1'b0, 1'b1, 8'h01);
    access(8'h90, 1'b1, 1'b0, 8'h00);    // R4 slot 0x10
    access(8'h8F, 1'b0, 1'b1, 8'h00);
    access(8'h80, 1'b1, 1'b0, 8'h00);    // R3 slot 0
    summary();
  end
endmodule